// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a programmable interval timer for a processor subsystem. A free-running power-of-two prescaler divides the core clock into timer ticks, and a 16-bit down counter decrements once per tick. When the count runs out, the block raises a one-cycle interrupt pulse. The counter then either parks at zero or reloads itself from a period register, so the block serves as a single-shot delay or as a periodic interrupt source.

Software drives the block through a simple single-cycle register bus. The bus has a write strobe, a two-bit register address, write data and combinational read data. Three registers are decoded: a control word, the period and the live count. The control word carries the prescale code, a count-enable bit, a repeat-mode bit and a halt bit. The halt bit freezes both the prescaler and the counter. A cleared enable bit only holds the count. Neither bit destroys any stored value.

Top module: `interval_timer`

## Requirements
- R1: The control register keeps bit 6 as halt, bit 5 as repeat mode, bit 4 as count enable and bits 3..0 as the prescale code. Bits 15..7 always read back as zero, whatever was written to them.
- R2: With prescale code p, the counter receives one tick every 2^(p+1) clock cycles. Code 0 gives 2 cycles and code 15 gives 65536 cycles.
- R3: While enabled and not halted, each tick lowers the count by one.
- R4: With the enable bit at 0, the count holds and no interrupt is raised.
- R5: With the halt bit at 1, the prescaler phase and the count both freeze and no interrupt is raised. Count and period keep their values, and when halt is released, counting resumes from the frozen count.
- R6: In stop mode (repeat bit 0), a tick at count 1 moves the count to 0 and raises the interrupt. At count 0 the count stays at 0 with no further interrupt.
- R7: In repeat mode, a tick at count 1 loads the period value and raises the interrupt, so interrupts come every period × 2^(p+1) cycles. A tick at count 0 in repeat mode loads the period without raising an interrupt.
- R8: The interrupt output is high for exactly one cycle. That cycle is the one in which the count register first shows its post-expiry value.
- R9: A write to the count register loads the value directly. It takes priority over a tick in the same cycle and suppresses that tick's interrupt. A write to the period register changes only the value used at the next reload.
- R10: A control write whose prescale code differs from the current one restarts the prescaler from zero, so the first tick after the write arrives exactly 2^(p+1) cycles later.
- R11: Synchronous active-low reset clears the control word, the period, the count, the prescaler and the interrupt.
- R12: Address 0 selects control, address 1 selects period, address 2 selects count, and address 3 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-cycle timer interrupt |

## Verification
A wrong prescaler phase shows up as a count that steps one or more cycles early or late. It becomes visible at the first tick after a prescale change, which is at most 65536 cycles away and only 2 to 16 cycles away for the codes used most. A corrupted count or reload value shows up in a count read-back at once. It also shows up as a misplaced interrupt at the next expiry. Because a reference model runs alongside the design and the read data and interrupt are compared every cycle, any divergence is reported in the cycle where it first reaches the ports.

// File: rtl/tmr_pkg.sv
// Package: shared types and constants for the interval timer.
// Assumes a 16-bit bus and a four-bit prescale code.
package tmr_pkg;

    localparam int PSEL_W = 4;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTL    = 2'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

    // Control word, packed so that bit 6 is halt and bits 3..0 are the code.
    typedef struct packed {
        logic              halt;
        logic              repeat_mode;
        logic              count_en;
        logic [PSEL_W-1:0] psel;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/tmr_regs.sv
// Module: tmr_regs
// Holds the control word and the period. Decodes bus writes and muxes the
// read data. Flags a prescale-code change so the prescaler can restart.
// Assumes single-cycle writes, with read data sampled combinationally.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_q,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] period_q,
    output logic              psel_restart,
    output logic              cnt_load,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - CTL_W;

    logic wr_ctl;
    logic wr_period;

    // Write-address decode.
    always_comb begin
        wr_ctl    = wr_en && (addr == A_CTL);
        wr_period = wr_en && (addr == A_PERIOD);
        cnt_load  = wr_en && (addr == A_COUNT);
    end

    // Prescale restart when a control write changes the code.
    always_comb begin
        psel_restart = wr_ctl && (wdata[PSEL_W-1:0] != ctl_q.psel);
    end

    // Control register; only the defined low bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_ctl)
            ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
    end

    // Period register, used only at reload time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= '0;
        else if (wr_period)
            period_q <= wdata;
    end

    // Read multiplexer; reserved bits and the unused address read zero.
    always_comb begin
        unique case (addr)
            A_CTL:    rdata = {{PAD_W{1'b0}}, ctl_q};
            A_PERIOD: rdata = period_q;
            A_COUNT:  rdata = count_q;
            default:  rdata = '0;
        endcase
    end

    // R9: period only moves on its own write.
    a_r9_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_period |=> $stable(period_q));

    // R1: control only moves on a control write.
    a_r1_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctl |=> $stable(ctl_q));

endmodule

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// A power-of-two clock divider. It emits a one-cycle tick every
// 2^(psel+1) cycles. Halt freezes its phase, and restart zeroes it.
// Assumes PSEL_W is small enough that 2^PSEL_W phase bits are cheap.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int SEL_W = PSEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] psel,
    input  logic             halt,
    input  logic             restart,
    output logic             tick
);

    localparam int PS_W = 1 << SEL_W;

    logic [PS_W-1:0] ps_q;
    logic [PS_W:0]   lim_wide;
    logic [PS_W-1:0] lim;

    // Terminal phase for the selected division, 2^(psel+1)-1.
    always_comb begin
        lim_wide = ({{PS_W{1'b0}}, 1'b1} << ({1'b0, psel} + 1'b1)) - 1'b1;
        lim      = lim_wide[PS_W-1:0];
    end

    // Tick on the terminal phase while running.
    always_comb begin
        tick = !halt && (ps_q == lim);
    end

    // Phase counter: restart, freeze, wrap or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ps_q <= '0;
        else if (restart)
            ps_q <= '0;
        else if (halt)
            ps_q <= ps_q;
        else if (tick)
            ps_q <= '0;
        else
            ps_q <= ps_q + 1'b1;
    end

    // R2: a tick always starts a fresh interval.
    a_r2_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (ps_q == '0));

    // R5: halt freezes the prescaler phase.
    a_r5_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> $stable(ps_q));

    // R10: a code change zeroes the phase.
    a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ps_q == '0));

endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// The down counter with stop or repeat handling and a registered interrupt.
// Assumes tick is already gated by halt upstream. A bus load wins over a tick.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             count_en,
    input  logic             repeat_mode,
    input  logic [CNT_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_q
);

    logic             step;
    logic             at_one;
    logic             at_zero;
    logic [CNT_W-1:0] count_nxt;
    logic             irq_nxt;

    // Qualify the tick and classify the current count.
    always_comb begin
        step    = tick && count_en && !load;
        at_one  = (count_q == CNT_W'(1));
        at_zero = (count_q == '0);
    end

    // Next count and interrupt request.
    always_comb begin
        count_nxt = count_q;
        irq_nxt   = 1'b0;
        if (load) begin
            count_nxt = load_val;
        end else if (step) begin
            if (at_one) begin
                count_nxt = repeat_mode ? period : '0;
                irq_nxt   = 1'b1;
            end else if (at_zero) begin
                count_nxt = repeat_mode ? period : count_q;
            end else begin
                count_nxt = count_q - 1'b1;
            end
        end
    end

    // Count and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            count_q <= count_nxt;
            irq_q   <= irq_nxt;
        end
    end

    // R8: the interrupt never lasts two cycles.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6: an interrupt follows a cycle in which the count was one.
    a_r6_irq_from_one: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(count_q) == CNT_W'(1)));

    // R9: a bus load lands unchanged.
    a_r9_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)));

endmodule

// File: rtl/interval_timer.sv
// Module: interval_timer (top)
// Register file, prescaler and down counter wired into a periodic or
// single-shot interrupt source on a single-cycle register bus.
// Assumes synchronous active-low reset and a bus no wider than the count.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse
);

    ctl_t              ctl_q;
    logic [DATA_W-1:0] period_q;
    logic [DATA_W-1:0] count_q;
    logic              psel_restart;
    logic              cnt_load;
    logic              tick;

    tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .count_q      (count_q),
        .ctl_q        (ctl_q),
        .period_q     (period_q),
        .psel_restart (psel_restart),
        .cnt_load     (cnt_load),
        .rdata        (bus_rdata)
    );

    tmr_prescaler #(.SEL_W(PSEL_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (ctl_q.psel),
        .halt    (ctl_q.halt),
        .restart (psel_restart),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .count_en    (ctl_q.count_en),
        .repeat_mode (ctl_q.repeat_mode),
        .period      (period_q),
        .load        (cnt_load),
        .load_val    (bus_wdata),
        .count_q     (count_q),
        .irq_q       (irq_pulse)
    );

    // R4: a disabled counter holds its count.
    a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.count_en && !cnt_load) |=> ($stable(count_q) && !irq_pulse));

    // R5: halt freezes the count and silences the interrupt.
    a_r5_halt_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.halt && !cnt_load) |=> ($stable(count_q) && !irq_pulse));

    // R3: without a load, the count never rises except by a reload.
    a_r3_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_load && !ctl_q.repeat_mode) |=> (count_q <= $past(count_q)));

endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    interval_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    // Reference model state, built from the requirements.
    logic [6:0]  m_ctl;
    logic [15:0] m_per, m_cnt, m_ps;
    logic        m_irq;

    function automatic logic [15:0] m_lim(input logic [3:0] p);
        int unsigned v;
        v = (32'd1 << (int'(p) + 1)) - 1;
        return v[15:0];
    endfunction

    function automatic logic [15:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {9'd0, m_ctl};
            2'd1:    return m_per;
            2'd2:    return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic tk, ld;
        if (!rst_n) begin
            m_ctl <= '0; m_per <= '0; m_cnt <= '0; m_ps <= '0; m_irq <= 1'b0;
        end else begin
            tk = !m_ctl[6] && (m_ps == m_lim(m_ctl[3:0]));
            ld = bus_wr && bus_addr == 2'd2;
            if (bus_wr && bus_addr == 2'd0 && bus_wdata[3:0] != m_ctl[3:0]) m_ps <= '0;
            else if (m_ctl[6]) m_ps <= m_ps;
            else if (tk) m_ps <= '0;
            else m_ps <= m_ps + 1'b1;
            m_irq <= 1'b0;
            if (ld) m_cnt <= bus_wdata;
            else if (tk && m_ctl[4]) begin
                if (m_cnt == 16'd1) begin
                    m_cnt <= m_ctl[5] ? m_per : 16'd0;
                    m_irq <= 1'b1;
                end else if (m_cnt == 16'd0) begin
                    if (m_ctl[5]) m_cnt <= m_per;
                end else m_cnt <= m_cnt - 1'b1;
            end
            if (bus_wr && bus_addr == 2'd0) m_ctl <= bus_wdata[6:0];
            if (bus_wr && bus_addr == 2'd1) m_per <= bus_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Continuous comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R12 read data vs model", bus_rdata, m_read(bus_addr));
            chk("R8 interrupt vs model", irq_pulse, m_irq);
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v, held;
        int n, first;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state.
        rd(2'd0, v); chk("R11 control after reset", v, 16'h0000);
        rd(2'd1, v); chk("R11 period after reset", v, 16'h0000);
        rd(2'd2, v); chk("R11 count after reset", v, 16'h0000);
        chk("R11 irq after reset", irq_pulse, 1'b0);

        // R1 and R12: field layout, reserved bits and unused address.
        bus_write(2'd0, 16'hFFFF);
        rd(2'd0, v); chk("R1 reserved bits read zero", v, 16'h007F);
        bus_write(2'd3, 16'hABCD);
        rd(2'd3, v); chk("R12 address 3 reads zero", v, 16'h0000);
        bus_write(2'd0, 16'h0040);

        // R2, R3 and R6: code 1 divides by 4; stop mode ends at zero.
        bus_write(2'd2, 16'd3);
        bus_write(2'd0, 16'h0011);
        n = 0;
        do begin @(negedge clk); n++; rd(2'd2, v); end while (v != 16'd2 && n < 100);
        chk("R2 first tick after 4 cycles", n, 4);
        do begin @(negedge clk); n++; rd(2'd2, v); end while (v != 16'd0 && n < 100);
        chk("R3 count reaches zero after 3 ticks", n, 12);
        chk("R6 interrupt at expiry", irq_pulse, 1'b1);
        @(negedge clk);
        chk("R8 interrupt lasts one cycle", irq_pulse, 1'b0);
        first = 0;
        repeat (20) begin @(negedge clk); if (irq_pulse) first++; end
        rd(2'd2, v);
        chk("R6 stays at zero", v, 16'd0);
        chk("R6 no further interrupts", first, 0);

        // R7: repeat mode, period 2, code 1.
        bus_write(2'd0, 16'h0000);
        bus_write(2'd1, 16'd2);
        bus_write(2'd2, 16'd1);
        bus_write(2'd0, 16'h0031);
        n = 0; first = -1;
        while (n < 40) begin
            @(negedge clk); n++;
            if (irq_pulse) begin
                if (first < 0) begin
                    first = n;
                    rd(2'd2, v); chk("R7 reload value", v, 16'd2);
                end else begin
                    chk("R7 interrupt spacing", n - first, 8);
                    break;
                end
            end
        end
        chk("R7 first interrupt", first, 4);

        // R9: a new period takes effect at the next reload; a direct count write.
        bus_write(2'd1, 16'd5);
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_pulse && n < 100);
        rd(2'd2, v); chk("R9 new period used at reload", v, 16'd5);
        bus_write(2'd2, 16'd100);
        rd(2'd2, v); chk("R9 direct count load", v, 16'd100);

        // R4: enable off holds the count.
        bus_write(2'd0, 16'h0021);
        rd(2'd2, held);
        first = 0;
        repeat (20) begin @(negedge clk); if (irq_pulse) first++; end
        rd(2'd2, v); chk("R4 count held while disabled", v, held);
        chk("R4 no interrupt while disabled", first, 0);

        // R5: halt freezes everything and keeps values.
        bus_write(2'd2, 16'd40);
        bus_write(2'd0, 16'h0051);
        repeat (30) @(negedge clk);
        rd(2'd2, v); chk("R5 count frozen under halt", v, 16'd40);
        rd(2'd1, v); chk("R5 period kept under halt", v, 16'd5);
        bus_write(2'd0, 16'h0011);
        repeat (10) @(negedge clk);
        rd(2'd2, v); chk("R5 counting resumes after halt", (v < 16'd40 && v > 16'd30), 1'b1);

        // R10: a code change restarts the prescaler.
        bus_write(2'd0, 16'h0003);
        bus_write(2'd2, 16'd50);
        repeat (5) @(negedge clk);
        bus_write(2'd0, 16'h0012);
        n = 0;
        do begin @(negedge clk); n++; rd(2'd2, v); end while (v == 16'd50 && n < 100);
        chk("R10 first tick full new interval", n, 8);

        // R2: largest code divides by 65536.
        bus_write(2'd0, 16'h0002);
        bus_write(2'd2, 16'd1);
        bus_write(2'd0, 16'h001F);
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_pulse && n < 70000);
        chk("R2 code 15 interval", n, 65536);

        // Random phase with small prescale codes, checked by the model.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(7) == 0) begin
                bus_wr = 1'b1;
                bus_addr = 2'($urandom_range(3));
                if (bus_addr == 2'd0) bus_wdata = 16'($urandom) & 16'hFFF3;
                else bus_wdata = 16'($urandom_range(7));
                if (bus_addr == 2'd0 && $urandom_range(3) != 0) bus_wdata[6] = 1'b0;
            end else begin
                bus_wr = 1'b0;
                bus_addr = 2'($urandom_range(3));
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule